// File: doc/BRIEF.md
# Dual-Channel Converter Command Controller

This block holds the digital state of a two-channel voltage-output converter that is programmed over a three-wire serial link. A host lowers a select line, clocks in a 16-bit word on the data line and then raises the select line. On that rising edge the word is decoded. Depending on its command it writes a staging register, copies staging values into the live code registers, or changes the power state of one or both channels and of the shared bias circuit.

The serial pins and the load strobe are sampled by the system clock `clk`. The serial clock must therefore run at least four times slower than `clk`. The load strobe is level-sensitive. While it is held low, every system clock copies both staging registers into the live registers. The outputs are the two live codes and the power state: an active flag and a termination-select flag per channel, and a bias-on flag.

Top module: `dacctl_top`

## Requirements
- R1: A word is taken MSB first on rising `ser_clk` edges while `ser_cs_n` is low. Bits 15..13 are the opcode, bits 12..3 are the data D9..D0 and bits 2..0 are the tail. The word takes effect two `clk` cycles after `ser_cs_n` is sampled rising.
- R2: A word is discarded with no effect if the number of clock edges is not exactly 16, or if its tail bits are not all zero.
- R3: Opcode 010 writes the data to staging register A. Opcode 101 writes the data to staging register B. In both cases the live codes and the power state stay the same.
- R4: Opcode 001 writes staging A and opcode 110 writes staging B. Both then copy both staging registers into the live registers, so the live code of the written channel equals the new data.
- R5: Opcode 011 writes the data to both staging and both live registers. Opcode 100 copies both staging registers into the live registers and ignores the data field.
- R6: Opcode 111 shuts down both channels. It sets the termination select of A from D9 and that of B from D8, where 1 selects the high-impedance termination. It leaves the bias flag unchanged.
- R7: Opcode 000 with D9..D7 = 001 copies staging A into live A. With D9..D7 = 101 it copies staging B into live B. The other channel is not touched.
- R8: Opcode 000 with D9..D7 = 011 turns the bias off and shuts down both channels. D6 becomes the termination select of A and D5 the termination select of B.
- R9: Opcode 000 with D9..D7 = 110 shuts down A and sets its select from D6. With D9..D7 = 111 it shuts down B and sets its select from D6.
- R10: Any command that updates a live register makes that channel active and turns the bias on. The other channel's active flag is unchanged.
- R11: While `load_n` is low, both live registers take the staging values every `clk` cycle. The active flags are not changed by this.
- R12: After reset all four registers hold zero, both channels are active, the bias is on and both selects are 1.
- R13: Opcode 000 with D9..D7 equal to 000, 010 or 100 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_cs_n | input | 1 | Serial select, low while a word is sent |
| ser_clk | input | 1 | Serial bit clock, data taken on its rising edge |
| ser_din | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low level strobe that copies staging into live registers |
| code_a | output | 10 | Live code of channel A |
| code_b | output | 10 | Live code of channel B |
| active_a | output | 1 | Channel A is powered |
| active_b | output | 1 | Channel B is powered |
| load_hi_a | output | 1 | Channel A termination select (1 = high impedance) |
| load_hi_b | output | 1 | Channel B termination select (1 = high impedance) |
| bias_on | output | 1 | Shared bias circuit is on |

## Verification
The bench targets words of 15 and 17 bits. A bad edge counter would execute a truncated or shifted command there. It also sends a word with a nonzero tail, which a design that skips the tail check would act on. It checks that the load-and-update opcodes take the other channel's live value from its staging register and not from the incoming data. It checks that a single-channel wake after full power-down restores the bias and leaves the other channel off. It holds the strobe low while a channel is shut down; a design that wakes on the strobe would raise that channel's active flag.

// File: rtl/dacctl_pkg.sv
package dacctl_pkg;

    localparam int NCH  = 2;
    localparam int OP_W = 3;
    localparam int EX_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_EXT      = 3'b000,
        OP_LDA_UPD  = 3'b001,
        OP_LDA      = 3'b010,
        OP_LD_BOTH  = 3'b011,
        OP_UPD_BOTH = 3'b100,
        OP_LDB      = 3'b101,
        OP_LDB_UPD  = 3'b110,
        OP_SD_BOTH  = 3'b111
    } opcode_e;

    typedef enum logic [EX_W-1:0] {
        EX_UPD_A   = 3'b001,
        EX_FULL_PD = 3'b011,
        EX_UPD_B   = 3'b101,
        EX_SD_A    = 3'b110,
        EX_SD_B    = 3'b111
    } extcmd_e;

    // index 0 is channel A, index 1 is channel B
    typedef struct packed {
        logic [NCH-1:0] ld_in;
        logic [NCH-1:0] upd;
        logic [NCH-1:0] sd;
        logic [NCH-1:0] sel_we;
        logic [NCH-1:0] sel_val;
        logic           bias_off;
    } cmd_t;

endpackage

// File: rtl/dacctl_shift.sv
module dacctl_shift #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_cs_n,
    input  logic               ser_clk,
    input  logic               ser_din,
    output logic               frame_stb,
    output logic [FRAME_W-1:0] frame
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_EXACT = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic               sclk;
        logic               cs;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sr;
        logic               stb;
        logic [FRAME_W-1:0] frame;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.sclk = ser_clk;
        sh_d.cs   = ser_cs_n;
        sh_d.stb  = 1'b0;
        if (!ser_cs_n && ser_clk && !sh_q.sclk) begin
            sh_d.sr = {sh_q.sr[FRAME_W-2:0], ser_din};
            if (sh_q.cnt != CNT_SAT) sh_d.cnt = sh_q.cnt + 1'b1;
        end
        if (ser_cs_n && !sh_q.cs) begin
            sh_d.cnt = '0;
            if (sh_q.cnt == CNT_EXACT) begin
                sh_d.stb   = 1'b1;
                sh_d.frame = sh_q.sr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q.sclk  <= 1'b0;
            sh_q.cs    <= 1'b1;
            sh_q.cnt   <= '0;
            sh_q.sr    <= '0;
            sh_q.stb   <= 1'b0;
            sh_q.frame <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign frame_stb = sh_q.stb;
    assign frame     = sh_q.frame;

    assert_stb_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.stb |=> !sh_q.stb);

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.cnt <= CNT_SAT);

    assert_cs_high_no_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.cs && ser_cs_n) |=> (sh_q.cnt == '0));

endmodule

// File: rtl/dacctl_decode.sv
module dacctl_decode
    import dacctl_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int SUB_W  = 3
) (
    input  logic [OP_W+DATA_W+SUB_W-1:0] frame,
    output cmd_t                         cmd,
    output logic [DATA_W-1:0]            data,
    output logic                         ok
);
    localparam int FRAME_W = OP_W + DATA_W + SUB_W;

    opcode_e           op;
    logic [EX_W-1:0]   ext;
    logic [SUB_W-1:0]  tail;
    logic              d_hi0, d_hi1, d_ext0, d_ext1;

    always_comb begin
        op     = opcode_e'(frame[FRAME_W-1 -: OP_W]);
        data   = frame[SUB_W +: DATA_W];
        tail   = frame[SUB_W-1:0];
        ext    = data[DATA_W-1 -: EX_W];
        d_hi0  = data[DATA_W-1];
        d_hi1  = data[DATA_W-2];
        d_ext0 = data[DATA_W-1-EX_W];
        d_ext1 = data[DATA_W-2-EX_W];
        ok     = (tail == '0);
        cmd    = '0;
        case (op)
            OP_LDA_UPD:  begin cmd.ld_in = 2'b01; cmd.upd = 2'b11; end
            OP_LDA:      begin cmd.ld_in = 2'b01; end
            OP_LD_BOTH:  begin cmd.ld_in = 2'b11; cmd.upd = 2'b11; end
            OP_UPD_BOTH: begin cmd.upd = 2'b11; end
            OP_LDB:      begin cmd.ld_in = 2'b10; end
            OP_LDB_UPD:  begin cmd.ld_in = 2'b10; cmd.upd = 2'b11; end
            OP_SD_BOTH: begin
                cmd.sd      = 2'b11;
                cmd.sel_we  = 2'b11;
                cmd.sel_val = {d_hi1, d_hi0};
            end
            default: begin
                case (ext)
                    EX_UPD_A: cmd.upd = 2'b01;
                    EX_UPD_B: cmd.upd = 2'b10;
                    EX_FULL_PD: begin
                        cmd.bias_off = 1'b1;
                        cmd.sd       = 2'b11;
                        cmd.sel_we   = 2'b11;
                        cmd.sel_val  = {d_ext1, d_ext0};
                    end
                    EX_SD_A: begin
                        cmd.sd      = 2'b01;
                        cmd.sel_we  = 2'b01;
                        cmd.sel_val = {1'b0, d_ext0};
                    end
                    EX_SD_B: begin
                        cmd.sd      = 2'b10;
                        cmd.sel_we  = 2'b10;
                        cmd.sel_val = {d_ext0, 1'b0};
                    end
                    default: cmd = '0;
                endcase
            end
        endcase
    end

    always_comb begin
        assert_upd_sd_exclusive_R10: assert ((cmd.upd & cmd.sd) == '0);
    end

endmodule

// File: rtl/dacctl_regs.sv
module dacctl_regs
    import dacctl_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_stb,
    input  cmd_t                         cmd,
    input  logic [DATA_W-1:0]            data,
    input  logic                         load_n,
    output logic [NCH-1:0][DATA_W-1:0]   dac,
    output logic [NCH-1:0]               act,
    output logic [NCH-1:0]               sel,
    output logic                         bias
);
    typedef struct packed {
        logic [NCH-1:0][DATA_W-1:0] in;
        logic [NCH-1:0][DATA_W-1:0] dac;
        logic [NCH-1:0]             act;
        logic [NCH-1:0]             sel;
        logic                       bias;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (cmd_stb) begin
            for (int c = 0; c < NCH; c++) begin
                if (cmd.ld_in[c])  rf_d.in[c]  = data;
                if (cmd.sel_we[c]) rf_d.sel[c] = cmd.sel_val[c];
                if (cmd.sd[c])     rf_d.act[c] = 1'b0;
            end
            if (cmd.bias_off) rf_d.bias = 1'b0;
            for (int c = 0; c < NCH; c++) begin
                if (cmd.upd[c]) begin
                    rf_d.dac[c] = rf_d.in[c];
                    rf_d.act[c] = 1'b1;
                    rf_d.bias   = 1'b1;
                end
            end
        end
        if (!load_n) begin
            for (int c = 0; c < NCH; c++) rf_d.dac[c] = rf_d.in[c];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q.in   <= '0;
            rf_q.dac  <= '0;
            rf_q.act  <= '1;
            rf_q.sel  <= '1;
            rf_q.bias <= 1'b1;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign dac  = rf_q.dac;
    assign act  = rf_q.act;
    assign sel  = rf_q.sel;
    assign bias = rf_q.bias;

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        assert_update_wakes_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_stb && cmd.upd[g]) |=> (rf_q.act[g] && rf_q.bias));
    end

    assert_strobe_no_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !cmd_stb) |=> $stable(rf_q.act));

    assert_strobe_copies_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (rf_q.dac == rf_q.in));

    assert_full_pd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd.bias_off) |=> (!rf_q.bias && rf_q.act == '0));

    assert_bias_off_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_q.bias |-> (rf_q.act == '0));

endmodule

// File: rtl/dacctl_top.sv
module dacctl_top
    import dacctl_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int SUB_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_cs_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              load_n,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic              active_a,
    output logic              active_b,
    output logic              load_hi_a,
    output logic              load_hi_b,
    output logic              bias_on
);
    localparam int FRAME_W = OP_W + DATA_W + SUB_W;

    logic                       frame_stb;
    logic [FRAME_W-1:0]         frame;
    cmd_t                       cmd;
    logic [DATA_W-1:0]          data;
    logic                       ok;
    logic [NCH-1:0][DATA_W-1:0] dac;
    logic [NCH-1:0]             act;
    logic [NCH-1:0]             sel;

    dacctl_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_cs_n  (ser_cs_n),
        .ser_clk   (ser_clk),
        .ser_din   (ser_din),
        .frame_stb (frame_stb),
        .frame     (frame)
    );

    dacctl_decode #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_decode (
        .frame (frame),
        .cmd   (cmd),
        .data  (data),
        .ok    (ok)
    );

    dacctl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_stb (frame_stb && ok),
        .cmd     (cmd),
        .data    (data),
        .load_n  (load_n),
        .dac     (dac),
        .act     (act),
        .sel     (sel),
        .bias    (bias_on)
    );

    assign code_a    = dac[0];
    assign code_b    = dac[1];
    assign active_a  = act[0];
    assign active_b  = act[1];
    assign load_hi_a = sel[0];
    assign load_hi_b = sel[1];

endmodule

// File: tb/tb_dacctl_top.sv
module tb_dacctl_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_cs_n = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       load_n = 1'b1;
    logic [9:0] code_a, code_b;
    logic       active_a, active_b, load_hi_a, load_hi_b, bias_on;

    int checks = 0;
    int errors = 0;

    // reference state, index 0 = A, 1 = B
    logic [9:0] m_in [2];
    logic [9:0] m_dac[2];
    logic       m_act[2];
    logic       m_sel[2];
    logic       m_bias;

    always #2 clk = ~clk;

    dacctl_top dut (
        .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
        .ser_din(ser_din), .load_n(load_n), .code_a(code_a), .code_b(code_b),
        .active_a(active_a), .active_b(active_b), .load_hi_a(load_hi_a),
        .load_hi_b(load_hi_b), .bias_on(bias_on)
    );

    function automatic logic [15:0] mk(input logic [2:0] op, input logic [9:0] d,
                                       input logic [2:0] tail);
        return {op, d, tail};
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        cmp(tag, "code_a", code_a, m_dac[0]);
        cmp(tag, "code_b", code_b, m_dac[1]);
        cmp(tag, "active_a", active_a, m_act[0]);
        cmp(tag, "active_b", active_b, m_act[1]);
        cmp(tag, "load_hi_a", load_hi_a, m_sel[0]);
        cmp(tag, "load_hi_b", load_hi_b, m_sel[1]);
        cmp(tag, "bias_on", bias_on, m_bias);
    endtask

    task automatic wake(input int c);
        m_act[c] = 1'b1;
        m_bias   = 1'b1;
    endtask

    task automatic model(input logic [15:0] w);
        logic [2:0] op = w[15:13];
        logic [9:0] d  = w[12:3];
        if (w[2:0] != 3'b000) return;
        case (op)
            3'b001: begin m_in[0] = d; m_dac[0] = m_in[0]; m_dac[1] = m_in[1]; wake(0); wake(1); end
            3'b010: m_in[0] = d;
            3'b011: begin m_in[0] = d; m_in[1] = d; m_dac[0] = d; m_dac[1] = d; wake(0); wake(1); end
            3'b100: begin m_dac[0] = m_in[0]; m_dac[1] = m_in[1]; wake(0); wake(1); end
            3'b101: m_in[1] = d;
            3'b110: begin m_in[1] = d; m_dac[0] = m_in[0]; m_dac[1] = m_in[1]; wake(0); wake(1); end
            3'b111: begin m_act[0] = 0; m_act[1] = 0; m_sel[0] = d[9]; m_sel[1] = d[8]; end
            default: begin
                case (d[9:7])
                    3'b001: begin m_dac[0] = m_in[0]; wake(0); end
                    3'b101: begin m_dac[1] = m_in[1]; wake(1); end
                    3'b011: begin m_bias = 0; m_act[0] = 0; m_act[1] = 0; m_sel[0] = d[6]; m_sel[1] = d[5]; end
                    3'b110: begin m_act[0] = 0; m_sel[0] = d[6]; end
                    3'b111: begin m_act[1] = 0; m_sel[1] = d[6]; end
                    default: ;
                endcase
            end
        endcase
    endtask

    task automatic send_bits(input logic [15:0] w, input int nbits);
        @(negedge clk) ser_cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            ser_din = (i < 16) ? w[15-i] : 1'b0;
            ser_clk = 1'b0;
            @(negedge clk) ser_clk = 1'b1;
        end
        @(negedge clk) ser_clk = 1'b0;
        @(negedge clk) ser_cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] w);
        send_bits(w, 16);
        model(w);
    endtask

    task automatic t_reset;
        m_in[0] = 0; m_in[1] = 0; m_dac[0] = 0; m_dac[1] = 0;
        m_act[0] = 1; m_act[1] = 1; m_sel[0] = 1; m_sel[1] = 1; m_bias = 1;
        check_all("R12");
    endtask

    task automatic t_load_only;
        frame(mk(3'b010, 10'h2A5, 3'b000)); check_all("R3");
        frame(mk(3'b101, 10'h15A, 3'b000)); check_all("R3");
    endtask

    task automatic t_load_update;
        frame(mk(3'b001, 10'h3C3, 3'b000)); check_all("R4");
        frame(mk(3'b101, 10'h011, 3'b000));
        frame(mk(3'b110, 10'h0F0, 3'b000)); check_all("R4");
    endtask

    task automatic t_both;
        frame(mk(3'b011, 10'h3FF, 3'b000)); check_all("R5");
        frame(mk(3'b010, 10'h001, 3'b000));
        frame(mk(3'b101, 10'h200, 3'b000));
        frame(mk(3'b100, 10'h155, 3'b000)); check_all("R5");
    endtask

    task automatic t_sd_both;
        frame(mk(3'b111, 10'b0100000000, 3'b000)); check_all("R6");
        frame(mk(3'b010, 10'h123, 3'b000));
        frame(mk(3'b000, 10'b0010000000, 3'b000)); check_all("R7 R10");
        frame(mk(3'b101, 10'h321, 3'b000));
        frame(mk(3'b000, 10'b1010000000, 3'b000)); check_all("R7 R10");
    endtask

    task automatic t_full_pd;
        frame(mk(3'b000, 10'b0111000000, 3'b000)); check_all("R8");
        frame(mk(3'b111, 10'b1100000000, 3'b000)); check_all("R6 bias held off");
        frame(mk(3'b000, 10'b1010000000, 3'b000)); check_all("R10 bias wake");
    endtask

    task automatic t_single_sd;
        frame(mk(3'b000, 10'b1101000000, 3'b000)); check_all("R9");
        frame(mk(3'b000, 10'b1110000000, 3'b000)); check_all("R9");
        frame(mk(3'b100, 10'h000, 3'b000)); check_all("R10");
    endtask

    task automatic t_noop_ext;
        frame(mk(3'b000, 10'b0001111111, 3'b000)); check_all("R13");
        frame(mk(3'b000, 10'b0101111111, 3'b000)); check_all("R13");
        frame(mk(3'b000, 10'b1001111111, 3'b000)); check_all("R13");
    endtask

    task automatic t_frame_len;
        send_bits(mk(3'b011, 10'h0AA, 3'b000), 15); check_all("R2 short");
        send_bits(mk(3'b011, 10'h0AA, 3'b000), 17); check_all("R2 long");
        send_bits(mk(3'b011, 10'h0AA, 3'b001), 16); check_all("R2 tail");
        frame(mk(3'b011, 10'h0AA, 3'b000)); check_all("R1");
    endtask

    task automatic t_strobe;
        frame(mk(3'b000, 10'b1100000000, 3'b000));
        frame(mk(3'b010, 10'h2DE, 3'b000));
        frame(mk(3'b101, 10'h1ED, 3'b000));
        check_all("R11 before");
        @(negedge clk) load_n = 1'b0;
        repeat (3) @(negedge clk);
        load_n = 1'b1;
        m_dac[0] = m_in[0];
        m_dac[1] = m_in[1];
        @(negedge clk);
        check_all("R11");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_load_only;
        t_load_update;
        t_both;
        t_sd_both;
        t_full_pd;
        t_single_sd;
        t_noop_ext;
        t_frame_len;
        t_strobe;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule